// File: doc/BRIEF.md
# Peripheral Bus Bridge with Doubleword Splitting

This block sits between a 64-bit system bus and a 32-bit peripheral bus. It takes one system access at a time and carries it out on the peripheral side. It decodes the address into a one-hot select for one of several fixed-size peripheral slots. It derives byte enables from the access size and the low address bits.

A doubleword access is the only case that is resized. It becomes two back-to-back word transfers, lower address first. The two read words are merged into one 64-bit result. No other size conversion is done and alignment is not checked. An access that crosses a 32-bit boundary has undefined behaviour.

The system handshake completes with a single-cycle ready pulse. That pulse comes only after every peripheral transfer for the access has ended. The requester holds its request stable while waiting.

Top module: `pbus_bridge`

## Requirements
- R1: An address whose bits [31:17] equal the window base selects slot number addr[16:14]; during each transfer exactly that bit of `per_sel` is high, and `per_sel` is zero when no transfer is in progress.
- R2: An address outside the window, or inside it at a slot whose bit in the populated mask is clear, completes with `sys_err`=1 and no peripheral transfer. By default slots 0 to 6 are populated.
- R3: Size codes are 0 byte, 1 halfword, 2 word, 3 doubleword. For a byte access `per_be` is 1<<addr[1:0]. For a halfword it is 4'b0011<<(2*addr[1]). A word or doubleword uses 4'b1111. `per_addr` is the word address with bits [1:0] cleared.
- R4: A doubleword access produces two transfers, at addr with bits [2:0] cleared and then at that address plus 4. The first transfer writes `sys_wdata[31:0]` and the second writes `sys_wdata[63:32]`.
- R5: A doubleword read returns the first transfer's data in `sys_rdata[31:0]` and the second transfer's data in `sys_rdata[63:32]`.
- R6: A peripheral error on either half of an access gives `sys_err`=1. An error on the first half of a doubleword ends the access without issuing the second half.
- R7: `sys_ready` is a single-cycle pulse that comes only after the last peripheral transfer ends. `per_valid` and its address, byte enables and select stay unchanged until `per_ready`.
- R8: For byte, halfword and word accesses the 32-bit lane is chosen by addr[2]: 0 means bits [31:0] and 1 means bits [63:32]. Write data is taken from that lane and read data is returned in it, with the other lane zero.
- R9: After reset `per_valid` and `sys_ready` are low.
- R10: `per_master` and `per_write` carry the requester's master ID and direction during every transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_valid | input | 1 | System request present, held until ready |
| sys_ready | output | 1 | One-cycle completion pulse |
| sys_addr | input | 32 | System byte address |
| sys_size | input | 2 | Access size code |
| sys_write | input | 1 | 1 = write |
| sys_master | input | 4 | Requesting master ID |
| sys_wdata | input | 64 | System write data |
| sys_rdata | output | 64 | System read data, valid with ready |
| sys_err | output | 1 | Error response, valid with ready |
| per_valid | output | 1 | Peripheral transfer request |
| per_ready | input | 1 | Peripheral transfer accepted and ended |
| per_sel | output | 8 | One-hot peripheral slot select |
| per_addr | output | 32 | Peripheral word address |
| per_write | output | 1 | 1 = write |
| per_master | output | 4 | Forwarded master ID |
| per_be | output | 4 | Byte enables |
| per_wdata | output | 32 | Peripheral write data |
| per_rdata | input | 32 | Peripheral read data |
| per_err | input | 1 | Peripheral error response |

## Verification
The assertions check several properties on every cycle:
- the select is one-hot during a transfer,
- the transfer is held steady until accepted,
- the ready pulse lasts one cycle and never overlaps a peripheral transfer,
- byte enables are never empty,
- a clean first half of a doubleword is followed at once by the upper word,
- a first-half error ends the access at once with an error.

The bench scenarios cover what depends on the values themselves:
- the slot decode across every slot and size,
- byte-enable and lane steering at every aligned offset,
- assembly of split reads,
- error responses on unpopulated and out-of-window addresses and on each half of a doubleword.

// File: rtl/pbus_bridge_pkg.sv
package pbus_bridge_pkg;

    localparam int AW     = 32;
    localparam int SYS_DW = 64;
    localparam int PER_DW = 32;
    localparam int MID_W  = 4;
    localparam int BE_W   = PER_DW / 8;
    localparam int LO_W   = $clog2(BE_W);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } xsize_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_RESP
    } bstate_e;

    typedef struct packed {
        logic [AW-1:0]     addr;
        logic [SYS_DW-1:0] wdata;
        xsize_e            size;
        logic              write;
        logic [MID_W-1:0]  master;
    } req_t;

    function automatic logic [BE_W-1:0] be_of(input xsize_e sz, input logic [LO_W-1:0] lo);
        logic [BE_W-1:0] be;
        case (sz)
            SZ_BYTE: be = BE_W'(1) << lo;
            SZ_HALF: be = BE_W'(3) << {lo[LO_W-1:1], 1'b0};
            default: be = '1;
        endcase
        return be;
    endfunction

endpackage

// File: rtl/pbus_decode.sv
module pbus_decode
    import pbus_bridge_pkg::*;
#(
    parameter int            NSLOT     = 8,
    parameter int            SLOT_LSB  = 14,
    parameter logic [AW-1:0] WIN_BASE  = 32'h4000_0000,
    parameter logic [NSLOT-1:0] SLOT_MASK = 8'h7F
) (
    input  logic [AW-1:SLOT_LSB] addr_hi,
    output logic                 hit,
    output logic [NSLOT-1:0]     sel
);
    localparam int SLOT_W  = $clog2(NSLOT);
    localparam int WIN_LSB = SLOT_LSB + SLOT_W;

    logic              in_win;
    logic [SLOT_W-1:0] slot;

    assign in_win = (addr_hi[AW-1:WIN_LSB] == WIN_BASE[AW-1:WIN_LSB]);
    assign slot   = addr_hi[WIN_LSB-1:SLOT_LSB];

    for (genvar g = 0; g < NSLOT; g++) begin : g_sel
        assign sel[g] = in_win && SLOT_MASK[g] && (slot == SLOT_W'(g));
    end

    assign hit = |sel;
endmodule

// File: rtl/pbus_lane.sv
module pbus_lane
    import pbus_bridge_pkg::*;
(
    input  req_t              req,
    input  logic              phase_hi,
    output logic              lane,
    output logic [AW-1:0]     per_addr,
    output logic [BE_W-1:0]   per_be,
    output logic [PER_DW-1:0] per_wdata
);
    logic dword;

    assign dword     = (req.size == SZ_DWORD);
    assign lane      = dword ? phase_hi : req.addr[LO_W];
    assign per_addr  = {req.addr[AW-1:LO_W+1], lane, {LO_W{1'b0}}};
    assign per_be    = dword ? '1 : be_of(req.size, req.addr[LO_W-1:0]);
    assign per_wdata = req.wdata[lane*PER_DW +: PER_DW];
endmodule

// File: rtl/pbus_sequencer.sv
module pbus_sequencer
    import pbus_bridge_pkg::*;
#(
    parameter int NSLOT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_valid,
    input  req_t              sys_req,
    input  logic              dec_hit,
    input  logic [NSLOT-1:0]  dec_sel,
    input  logic              lane,
    input  logic              per_ready,
    input  logic              per_err,
    input  logic [PER_DW-1:0] per_rdata,
    output req_t              req_q,
    output logic              phase_hi,
    output logic              per_valid,
    output logic [NSLOT-1:0]  per_sel,
    output logic              sys_ready,
    output logic              sys_err,
    output logic [SYS_DW-1:0] sys_rdata
);
    bstate_e           state;
    logic [NSLOT-1:0]  sel_q;
    logic [SYS_DW-1:0] rdata_q;
    logic              err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            req_q   <= '0;
            sel_q   <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (sys_valid) begin
                        req_q   <= sys_req;
                        sel_q   <= dec_sel;
                        rdata_q <= '0;
                        err_q   <= !dec_hit;
                        state   <= dec_hit ? ST_LO : ST_RESP;
                    end
                end
                ST_LO: begin
                    if (per_ready) begin
                        rdata_q[lane*PER_DW +: PER_DW] <= per_rdata;
                        if (per_err) begin
                            err_q <= 1'b1;
                            state <= ST_RESP;
                        end else if (req_q.size == SZ_DWORD) begin
                            state <= ST_HI;
                        end else begin
                            state <= ST_RESP;
                        end
                    end
                end
                ST_HI: begin
                    if (per_ready) begin
                        rdata_q[lane*PER_DW +: PER_DW] <= per_rdata;
                        err_q <= per_err;
                        state <= ST_RESP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign phase_hi  = (state == ST_HI);
    assign per_valid = (state == ST_LO) || (state == ST_HI);
    assign per_sel   = per_valid ? sel_q : '0;
    assign sys_ready = (state == ST_RESP);
    assign sys_err   = sys_ready && err_q;
    assign sys_rdata = rdata_q;
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
    import pbus_bridge_pkg::*;
#(
    parameter int               NSLOT     = 8,
    parameter int               SLOT_LSB  = 14,
    parameter logic [AW-1:0]    WIN_BASE  = 32'h4000_0000,
    parameter logic [NSLOT-1:0] SLOT_MASK = 8'h7F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_valid,
    output logic              sys_ready,
    input  logic [AW-1:0]     sys_addr,
    input  logic [1:0]        sys_size,
    input  logic              sys_write,
    input  logic [MID_W-1:0]  sys_master,
    input  logic [SYS_DW-1:0] sys_wdata,
    output logic [SYS_DW-1:0] sys_rdata,
    output logic              sys_err,
    output logic              per_valid,
    input  logic              per_ready,
    output logic [NSLOT-1:0]  per_sel,
    output logic [AW-1:0]     per_addr,
    output logic              per_write,
    output logic [MID_W-1:0]  per_master,
    output logic [BE_W-1:0]   per_be,
    output logic [PER_DW-1:0] per_wdata,
    input  logic [PER_DW-1:0] per_rdata,
    input  logic              per_err
);
    req_t             sys_req;
    req_t             req_q;
    logic             dec_hit;
    logic [NSLOT-1:0] dec_sel;
    logic             phase_hi;
    logic             lane;

    assign sys_req = '{addr: sys_addr, wdata: sys_wdata, size: xsize_e'(sys_size),
                       write: sys_write, master: sys_master};

    pbus_decode #(
        .NSLOT(NSLOT), .SLOT_LSB(SLOT_LSB), .WIN_BASE(WIN_BASE), .SLOT_MASK(SLOT_MASK)
    ) u_decode (
        .addr_hi (sys_addr[AW-1:SLOT_LSB]),
        .hit     (dec_hit),
        .sel     (dec_sel)
    );

    pbus_sequencer #(.NSLOT(NSLOT)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .sys_valid (sys_valid),
        .sys_req   (sys_req),
        .dec_hit   (dec_hit),
        .dec_sel   (dec_sel),
        .lane      (lane),
        .per_ready (per_ready),
        .per_err   (per_err),
        .per_rdata (per_rdata),
        .req_q     (req_q),
        .phase_hi  (phase_hi),
        .per_valid (per_valid),
        .per_sel   (per_sel),
        .sys_ready (sys_ready),
        .sys_err   (sys_err),
        .sys_rdata (sys_rdata)
    );

    pbus_lane u_lane (
        .req       (req_q),
        .phase_hi  (phase_hi),
        .lane      (lane),
        .per_addr  (per_addr),
        .per_be    (per_be),
        .per_wdata (per_wdata)
    );

    assign per_write  = req_q.write;
    assign per_master = req_q.master;
endmodule

// File: rtl/pbus_bridge_chk.sv
module pbus_bridge_chk
    import pbus_bridge_pkg::*;
#(
    parameter int NSLOT = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       sys_size,
    input logic             sys_ready,
    input logic             sys_err,
    input logic             per_valid,
    input logic             per_ready,
    input logic             per_err,
    input logic [NSLOT-1:0] per_sel,
    input logic [AW-1:0]    per_addr,
    input logic [BE_W-1:0]  per_be
);
    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        per_valid |-> $countones(per_sel) == 1);

    p_sel_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !per_valid |-> per_sel == '0);

    p_be_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        per_valid |-> per_be != '0);

    p_split_next_r4: assert property (@(posedge clk) disable iff (rst)
        (per_valid && per_ready && !per_err && sys_size == 2'd3 && !per_addr[2])
        |=> (per_valid && per_addr[2] && per_be == '1));

    p_err_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (per_valid && per_ready && per_err) |=> (sys_ready && sys_err && !per_valid));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (per_valid && !per_ready) |=>
        (per_valid && $stable(per_addr) && $stable(per_be) && $stable(per_sel)));

    p_ready_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        sys_ready |=> !sys_ready);

    p_ready_excl_r7: assert property (@(posedge clk) disable iff (rst)
        sys_ready |-> !per_valid);
endmodule

bind pbus_bridge pbus_bridge_chk #(.NSLOT(NSLOT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sys_size  (sys_size),
    .sys_ready (sys_ready),
    .sys_err   (sys_err),
    .per_valid (per_valid),
    .per_ready (per_ready),
    .per_err   (per_err),
    .per_sel   (per_sel),
    .per_addr  (per_addr),
    .per_be    (per_be)
);

// File: tb/pbus_bridge_bench.sv
`timescale 1ns/1ps
module pbus_bridge_bench;
    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam logic [7:0]  MASK = 8'h7F;

    logic        clk = 0;
    logic        rst = 1;
    logic        sys_valid = 0;
    logic        sys_ready;
    logic [31:0] sys_addr = 0;
    logic [1:0]  sys_size = 0;
    logic        sys_write = 0;
    logic [3:0]  sys_master = 0;
    logic [63:0] sys_wdata = 0;
    logic [63:0] sys_rdata;
    logic        sys_err;
    logic        per_valid;
    logic        per_ready = 0;
    logic [7:0]  per_sel;
    logic [31:0] per_addr;
    logic        per_write;
    logic [3:0]  per_master;
    logic [3:0]  per_be;
    logic [31:0] per_wdata;
    logic [31:0] per_rdata = 0;
    logic        per_err = 0;

    always #10 clk = ~clk;

    pbus_bridge u_pbus_bridge (.*);

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    // peripheral model and transfer recorder
    logic [31:0] err_addr = 0;
    logic        err_en = 0;
    int          wcnt = 0;
    int          lat = 0;
    int          rec_n = 0;
    logic [31:0] rec_addr [4];
    logic [3:0]  rec_be [4];
    logic [7:0]  rec_sel [4];
    logic [31:0] rec_wd [4];
    logic        rec_wr [4];
    logic [3:0]  rec_mid [4];

    function automatic logic [31:0] model(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[31:16] + 16'h0101};
    endfunction

    always @(negedge clk) begin
        if (rst || !per_valid) begin
            per_ready = 0;
            per_err = 0;
            wcnt = 0;
        end else if (wcnt >= lat) begin
            per_ready = 1;
            per_err = err_en && (per_addr == err_addr);
            per_rdata = model(per_addr);
            if (rec_n < 4) begin
                rec_addr[rec_n] = per_addr;
                rec_be[rec_n] = per_be;
                rec_sel[rec_n] = per_sel;
                rec_wd[rec_n] = per_wdata;
                rec_wr[rec_n] = per_write;
                rec_mid[rec_n] = per_master;
            end
            rec_n++;
            lat = (lat + 1) % 3;
            wcnt = 0;
        end else begin
            per_ready = 0;
            per_err = 0;
            wcnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic run_acc(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                           input logic [3:0] mid, input logic [63:0] wd);
        logic [63:0] rd;
        logic        er;
        int          w;
        bit          hit;
        int          exp_n;
        logic [31:0] ea [2];
        logic [3:0]  ebe [2];
        logic [31:0] ewd [2];
        logic [63:0] erd;
        bit          eerr;
        logic [7:0]  esel;
        int          lim;

        hit  = (a[31:17] == BASE[31:17]) && MASK[a[16:14]];
        esel = 8'd1 << a[16:14];
        if (sz == 2'd3) begin
            exp_n = 2;
            ea[0] = {a[31:3], 3'b000};
            ea[1] = {a[31:3], 3'b100};
            ebe[0] = 4'hF;
            ebe[1] = 4'hF;
            ewd[0] = wd[31:0];
            ewd[1] = wd[63:32];
            erd = {model(ea[1]), model(ea[0])};
        end else begin
            exp_n = 1;
            ea[0] = {a[31:2], 2'b00};
            ea[1] = 0;
            ebe[0] = (sz == 2'd0) ? (4'b0001 << a[1:0]) :
                     (sz == 2'd1) ? (4'b0011 << (2 * a[1])) : 4'hF;
            ebe[1] = 0;
            ewd[0] = a[2] ? wd[63:32] : wd[31:0];
            ewd[1] = 0;
            erd = a[2] ? {model(ea[0]), 32'h0} : {32'h0, model(ea[0])};
        end
        eerr = !hit;
        if (!hit) exp_n = 0;
        else if (err_en && ea[0] == err_addr) begin
            exp_n = 1;
            eerr = 1;
        end else if (err_en && sz == 2'd3 && ea[1] == err_addr) eerr = 1;

        @(negedge clk);
        rec_n = 0;
        sys_addr = a;
        sys_size = sz;
        sys_write = wr;
        sys_master = mid;
        sys_wdata = wd;
        sys_valid = 1;
        w = 0;
        do begin
            @(negedge clk);
            w++;
        end while (!sys_ready && w < 40);
        chk(sys_ready, "R7 ready reached", {63'b0, sys_ready}, 64'd1);
        rd = sys_rdata;
        er = sys_err;
        sys_valid = 0;
        @(negedge clk);
        chk(!sys_ready, "R7 ready single pulse", {63'b0, sys_ready}, 64'd0);

        chk(rec_n == exp_n, hit ? "R4/R6 transfer count" : "R2 no transfer on miss",
            64'(rec_n), 64'(exp_n));
        chk(er == eerr, hit ? "R6 error response" : "R2 miss error", {63'b0, er}, {63'b0, eerr});
        lim = (rec_n < exp_n) ? rec_n : exp_n;
        for (int i = 0; i < lim; i++) begin
            chk(rec_addr[i] == ea[i], "R4 transfer address", {32'b0, rec_addr[i]}, {32'b0, ea[i]});
            chk(rec_be[i] == ebe[i], "R3 byte enables", {60'b0, rec_be[i]}, {60'b0, ebe[i]});
            chk(rec_sel[i] == esel, "R1 slot select", {56'b0, rec_sel[i]}, {56'b0, esel});
            chk(rec_mid[i] == mid && rec_wr[i] == wr, "R10 master and direction",
                {59'b0, rec_wr[i], rec_mid[i]}, {59'b0, wr, mid});
            if (wr)
                chk(rec_wd[i] == ewd[i], "R8 write lane", {32'b0, rec_wd[i]}, {32'b0, ewd[i]});
        end
        if (!wr && !eerr)
            chk(rd == erd, (sz == 2'd3) ? "R5 read assembly" : "R8 read lane", rd, erd);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!per_valid && !sys_ready, "R9 reset outputs", {62'b0, per_valid, sys_ready}, 64'd0);
        rst = 0;
        @(negedge clk);
        chk(!per_valid && !sys_ready && per_sel == 0, "R9 idle after reset",
            {54'b0, per_sel, per_valid, sys_ready}, 64'd0);

        // sweep every slot, size, aligned offset and direction
        for (int s = 0; s < 8; s++)
            for (int z = 0; z < 4; z++)
                for (int o = 0; o < 8; o++)
                    for (int w = 0; w < 2; w++) begin
                        if ((o % (1 << z)) == 0)
                            run_acc(BASE + (s << 14) + 32'h0000_1230 + o, z[1:0], w[0],
                                    4'(s + z + o), {32'hD000_0000 + s * 64 + o, 32'h1000_0000 + z * 256 + w});
                    end

        // outside the window (R2)
        run_acc(BASE + 32'h0002_0008, 2'd2, 1'b1, 4'h3, 64'h1111_2222_3333_4444);
        run_acc(32'h0000_0010, 2'd3, 1'b0, 4'h5, 64'h0);
        run_acc(BASE - 4, 2'd2, 1'b0, 4'h6, 64'h0);

        // peripheral errors (R6)
        err_en = 1;
        err_addr = BASE + 32'h0000_4100;
        run_acc(BASE + 32'h0000_4100, 2'd2, 1'b1, 4'h1, 64'hAAAA_BBBB_CCCC_DDDD);
        run_acc(BASE + 32'h0000_4100, 2'd3, 1'b0, 4'h2, 64'h0);
        run_acc(BASE + 32'h0000_4100, 2'd3, 1'b1, 4'h2, 64'h0123_4567_89AB_CDEF);
        err_addr = BASE + 32'h0000_4104;
        run_acc(BASE + 32'h0000_4100, 2'd3, 1'b0, 4'h7, 64'h0);
        run_acc(BASE + 32'h0000_4100, 2'd3, 1'b1, 4'h7, 64'h0F0F_F0F0_5555_AAAA);
        run_acc(BASE + 32'h0000_4100, 2'd2, 1'b0, 4'h8, 64'h0);
        err_en = 0;
        run_acc(BASE + 32'h0000_4100, 2'd3, 1'b0, 4'h9, 64'h0);

        finish_run();
    end
endmodule